// File: doc/BRIEF.md
# Memory-Operand Addressing Form Decoder

This block turns the operand-addressing bytes of a variable-length instruction into a ready-made description of the operand. The inputs are the mode/register/rm byte, a scaled-index byte (used only when the form needs one), the three register-extension prefix bits, and the current address width. The outputs state whether the operand is a register or a memory reference. For a memory reference they give the base and index register numbers, each with a valid flag, the scale multiplier, the displacement width, a program-counter-relative flag, and whether a scaled-index byte belongs to the instruction.

All three address widths are covered, each with its irregular encodings. The 16-bit width uses a fixed table of base and index pairs. In 32-bit and 64-bit widths, rm=4 escapes to the scaled-index byte. The combination mod=0, rm=5 has no base in 32-bit width and is program-counter-relative in 64-bit width. Inside the scaled-index byte, index 4 means no index, and base 5 with mod=0 means no base. A length-computing fetch stage or an address generator upstream uses the result to know how many bytes follow and which registers to read. The decode is combinational logic followed by one output register stage with a synchronous active-low reset, so results appear one clock after the inputs.

Top module: `addr_form_dec`

## Requirements
- R1: While rst_n is low at a rising edge, every output becomes zero. Otherwise the outputs show the decode of the inputs sampled at the previous rising edge, one cycle of latency. Register numbers use the 4-bit encoding AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7, with the extension bit as bit 3. Displacement width codes are 0=none, 1=8 bits, 2=16 bits, 3=32 bits. A base or index number whose valid flag is clear reads 0.
- R2: When mod (modrm bits 7:6) is 3, in every width, o_is_reg is 1 and o_base carries {rex_b, rm} (rm being modrm bits 2:0). o_base_ok, o_index_ok and o_scale are 0, the displacement code is 0, and o_need_sib and o_rip_rel are 0.
- R3: In 32-bit and 64-bit widths, for a memory form that needs no scaled-index byte and is not the mod=0, rm=5 case, the base is {rex_b, rm} with the valid flag set and there is no index. mod=1 gives code 1 and mod=2 gives code 3; mod=0 gives code 0.
- R4: In 32-bit and 64-bit widths, mod=0 with rm=5 has no base and a 32-bit displacement. o_rip_rel is 1 in 64-bit width and 0 in 32-bit width, and this holds whatever rex_b is.
- R5: In 32-bit and 64-bit widths, a memory form with rm=4 sets o_need_sib. The base is {rex_b, sib bits 2:0} and is valid. The index is {rex_x, sib bits 5:3}. The displacement follows the rule of R3.
- R6: The scale is 1 shifted left by sib bits 7:6, giving 1, 2, 4 or 8, whenever the index is valid. An index number equal to 4 (with rex_x=0) marks the index invalid and forces the scale to 0. Index 12 is a valid index.
- R7: In the scaled-index form, a base whose low three bits are 5 combined with mod=0 gives no base and a 32-bit displacement. With mod=1 or mod=2 that base stays valid, with codes 1 and 3.
- R8: In 16-bit width, the memory forms for rm 0..7 give the base/index pairs BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX. A present index has scale 1. mod=1 gives code 1 and mod=2 gives code 2. mod=0 with rm=6 gives no base and code 2.
- R9: o_reg_fld is {rex_r, modrm bits 5:3}.
- R10: i_amode is encoded 0=16-bit, 1=32-bit, 2=64-bit, and 3 behaves as 32-bit. Outside 64-bit width, rex_b, rex_x and rex_r have no effect on any output.
- R11: In 16-bit width, o_need_sib and o_rip_rel are always 0, rm=4 included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_modrm | input | 8 | Mode/register/rm byte |
| i_sib | input | 8 | Scaled-index byte (used only when needed) |
| i_rex_b | input | 1 | Extension bit for rm or the scaled-index base |
| i_rex_x | input | 1 | Extension bit for the scaled index |
| i_rex_r | input | 1 | Extension bit for the reg field |
| i_amode | input | 2 | Address width: 0=16, 1=32, 2=64, 3=32 |
| o_is_reg | output | 1 | Operand is a register |
| o_reg_fld | output | 4 | Register number of the reg field |
| o_base | output | 4 | Base register number (register number in register form) |
| o_base_ok | output | 1 | Base register present |
| o_index | output | 4 | Index register number |
| o_index_ok | output | 1 | Index register present |
| o_scale | output | 4 | Index multiplier 1/2/4/8, 0 when no index |
| o_disp_sz | output | 2 | Displacement width code |
| o_rip_rel | output | 1 | Address is relative to the program counter |
| o_need_sib | output | 1 | A scaled-index byte follows |

## Verification
The scaled-index escape and the no-base rule can resolve in the same cycle. With rm=4 and mod=0, the scaled-index byte can name base 5 and index 4 together, and the operand then reduces to a bare 32-bit displacement with the scaled-index byte still required. A sweep over every scaled-index byte under each memory mod, with all combinations of the two extension bits, provokes this meeting along with its neighbours, base 13 and index 12. Every result is judged against an arithmetic model in the bench, built from the requirement text, and the whole output word is compared one cycle after the inputs are applied.

// File: rtl/addr_form_pkg.sv
// Shared types for the addressing form decoder.
// Assumes a 3-bit rm/index/base field widened to 4 bits by one extension bit.
package addr_form_pkg;
    localparam int BYTE_W  = 8;
    localparam int FLD_W   = 3;
    localparam int RNUM_W  = FLD_W + 1;
    localparam int SCALE_W = 4;

    typedef enum logic [1:0] {AM16 = 2'd0, AM32 = 2'd1, AM64 = 2'd2, AMRSV = 2'd3} amode_e;
    typedef enum logic [1:0] {DSP_NONE = 2'd0, DSP_8 = 2'd1, DSP_16 = 2'd2, DSP_32 = 2'd3} disp_e;

    localparam logic [RNUM_W-1:0] RN_BX = 4'd3;
    localparam logic [RNUM_W-1:0] RN_SP = 4'd4;
    localparam logic [RNUM_W-1:0] RN_BP = 4'd5;
    localparam logic [RNUM_W-1:0] RN_SI = 4'd6;
    localparam logic [RNUM_W-1:0] RN_DI = 4'd7;

    typedef struct packed {
        logic                is_reg;
        logic [RNUM_W-1:0]   base_num;
        logic                base_ok;
        logic [RNUM_W-1:0]   idx_num;
        logic                idx_ok;
        logic [SCALE_W-1:0]  scale;
        disp_e               disp;
        logic                rip_rel;
        logic                need_sib;
    } addr_form_t;
endpackage

// File: rtl/af_dec16.sv
// 16-bit width decoder: fixed base/index pair table and the 16-bit displacement rules.
// Assumes mod and rm are already split from the modrm byte; extension bits play no part.
module af_dec16
    import addr_form_pkg::*;
(
    input  logic [1:0]       i_mod,
    input  logic [FLD_W-1:0] i_rm,
    output addr_form_t       o_form
);
    // Look up the pair table and pick the displacement width.
    always_comb begin
        o_form = '0;
        if (i_mod == 2'd3) begin
            o_form.is_reg   = 1'b1;
            o_form.base_num = {1'b0, i_rm};
        end else begin
            o_form.base_ok = 1'b1;
            case (i_rm)
                3'd0: begin o_form.base_num = RN_BX; o_form.idx_num = RN_SI; o_form.idx_ok = 1'b1; end
                3'd1: begin o_form.base_num = RN_BX; o_form.idx_num = RN_DI; o_form.idx_ok = 1'b1; end
                3'd2: begin o_form.base_num = RN_BP; o_form.idx_num = RN_SI; o_form.idx_ok = 1'b1; end
                3'd3: begin o_form.base_num = RN_BP; o_form.idx_num = RN_DI; o_form.idx_ok = 1'b1; end
                3'd4: o_form.base_num = RN_SI;
                3'd5: o_form.base_num = RN_DI;
                3'd6: o_form.base_num = RN_BP;
                default: o_form.base_num = RN_BX;
            endcase
            if (o_form.idx_ok)
                o_form.scale = 4'd1;
            case (i_mod)
                2'd1: o_form.disp = DSP_8;
                2'd2: o_form.disp = DSP_16;
                default: begin
                    if (i_rm == 3'd6) begin
                        o_form.disp     = DSP_16;
                        o_form.base_ok  = 1'b0;
                        o_form.base_num = '0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/af_dec3264.sv
// 32/64-bit width decoder: scaled-index escape, no-base and PC-relative cases.
// Assumes the extension bits arrive already forced to zero outside 64-bit width.
module af_dec3264
    import addr_form_pkg::*;
(
    input  logic [1:0]        i_mod,
    input  logic [FLD_W-1:0]  i_rm,
    input  logic [BYTE_W-1:0] i_sib,
    input  logic              i_rex_b,
    input  logic              i_rex_x,
    input  logic              i_is64,
    output addr_form_t        o_form
);
    localparam logic [FLD_W-1:0] RM_ESC   = 3'd4;
    localparam logic [FLD_W-1:0] RM_NOBAS = 3'd5;

    logic [1:0]       sib_ss;
    logic [FLD_W-1:0] sib_ix;
    logic [FLD_W-1:0] sib_bs;

    // Split the scaled-index byte into its three fields.
    always_comb begin
        sib_ss = i_sib[7:6];
        sib_ix = i_sib[5:3];
        sib_bs = i_sib[2:0];
    end

    // Resolve the addressing form for the wide widths.
    always_comb begin
        o_form = '0;
        case (i_mod)
            2'd1: o_form.disp = DSP_8;
            2'd2: o_form.disp = DSP_32;
            default: o_form.disp = DSP_NONE;
        endcase
        if (i_mod == 2'd3) begin
            o_form.is_reg   = 1'b1;
            o_form.disp     = DSP_NONE;
            o_form.base_num = {i_rex_b, i_rm};
        end else if (i_rm == RM_ESC) begin
            o_form.need_sib = 1'b1;
            o_form.base_num = {i_rex_b, sib_bs};
            o_form.base_ok  = 1'b1;
            o_form.idx_num  = {i_rex_x, sib_ix};
            o_form.idx_ok   = ({i_rex_x, sib_ix} != RN_SP);
            if (o_form.idx_ok)
                o_form.scale = 4'd1 << sib_ss;
            else
                o_form.idx_num = '0;
            if (sib_bs == RM_NOBAS && i_mod == 2'd0) begin
                o_form.base_ok  = 1'b0;
                o_form.base_num = '0;
                o_form.disp     = DSP_32;
            end
        end else if (i_rm == RM_NOBAS && i_mod == 2'd0) begin
            o_form.disp    = DSP_32;
            o_form.rip_rel = i_is64;
        end else begin
            o_form.base_num = {i_rex_b, i_rm};
            o_form.base_ok  = 1'b1;
        end
    end
endmodule

// File: rtl/addr_form_dec.sv
// Top of the addressing form decoder: splits the modrm byte, gates the
// extension bits by width, selects the width-specific decode and registers it.
// Assumes inputs are stable for the setup window before each rising edge.
module addr_form_dec
    import addr_form_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] i_modrm,
    input  logic [BYTE_W-1:0] i_sib,
    input  logic              i_rex_b,
    input  logic              i_rex_x,
    input  logic              i_rex_r,
    input  logic [1:0]        i_amode,
    output logic              o_is_reg,
    output logic [RNUM_W-1:0] o_reg_fld,
    output logic [RNUM_W-1:0] o_base,
    output logic              o_base_ok,
    output logic [RNUM_W-1:0] o_index,
    output logic              o_index_ok,
    output logic [SCALE_W-1:0] o_scale,
    output logic [1:0]        o_disp_sz,
    output logic              o_rip_rel,
    output logic              o_need_sib
);
    logic [1:0]       mod_f;
    logic [FLD_W-1:0] reg_f;
    logic [FLD_W-1:0] rm_f;
    logic             is16;
    logic             is64;
    logic             rb_g;
    logic             rx_g;
    logic             rr_g;
    addr_form_t       form16;
    addr_form_t       form_w;
    addr_form_t       form_sel;
    addr_form_t       form_q;
    logic [RNUM_W-1:0] regfld_d;
    logic [RNUM_W-1:0] regfld_q;

    // Split modrm and gate the extension bits by address width.
    always_comb begin
        mod_f = i_modrm[7:6];
        reg_f = i_modrm[5:3];
        rm_f  = i_modrm[2:0];
        is16  = (i_amode == AM16);
        is64  = (i_amode == AM64);
        rb_g  = i_rex_b & is64;
        rx_g  = i_rex_x & is64;
        rr_g  = i_rex_r & is64;
        regfld_d = {rr_g, reg_f};
    end

    af_dec16 u_dec16 (
        .i_mod  (mod_f),
        .i_rm   (rm_f),
        .o_form (form16)
    );

    af_dec3264 u_decw (
        .i_mod   (mod_f),
        .i_rm    (rm_f),
        .i_sib   (i_sib),
        .i_rex_b (rb_g),
        .i_rex_x (rx_g),
        .i_is64  (is64),
        .o_form  (form_w)
    );

    // Pick the decode that matches the address width.
    always_comb begin
        form_sel = is16 ? form16 : form_w;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            form_q   <= '0;
            regfld_q <= '0;
        end else begin
            form_q   <= form_sel;
            regfld_q <= regfld_d;
        end
    end

    // Drive the ports from the registered form.
    always_comb begin
        o_is_reg   = form_q.is_reg;
        o_reg_fld  = regfld_q;
        o_base     = form_q.base_num;
        o_base_ok  = form_q.base_ok;
        o_index    = form_q.idx_num;
        o_index_ok = form_q.idx_ok;
        o_scale    = form_q.scale;
        o_disp_sz  = form_q.disp;
        o_rip_rel  = form_q.rip_rel;
        o_need_sib = form_q.need_sib;
    end
endmodule

// File: rtl/addr_form_chk.sv
// Checker for the addressing form decoder, bound to the top module.
// Assumes the one-cycle output latency of the top.
module addr_form_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] i_amode,
    input logic       o_is_reg,
    input logic       o_base_ok,
    input logic       o_index_ok,
    input logic [3:0] o_scale,
    input logic [1:0] o_disp_sz,
    input logic       o_rip_rel,
    input logic       o_need_sib
);
    assert_regform_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        o_is_reg |-> (o_disp_sz == 2'd0 && !o_need_sib && !o_index_ok && !o_base_ok && !o_rip_rel));

    assert_rip_disp32_R4: assert property (@(posedge clk) disable iff (!rst_n)
        o_rip_rel |-> (o_disp_sz == 2'd3 && !o_base_ok));

    assert_scale_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        o_index_ok |-> ($countones(o_scale) == 1));

    assert_scale_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !o_index_ok |-> (o_scale == 4'd0));

    assert_disp16_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_amode != 2'd0) |=> (o_disp_sz != 2'd2));

    assert_rip_only64_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (i_amode != 2'd2) |=> !o_rip_rel);

    assert_no_sib16_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (i_amode == 2'd0) |=> !o_need_sib);
endmodule

bind addr_form_dec addr_form_chk u_addr_form_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_amode    (i_amode),
    .o_is_reg   (o_is_reg),
    .o_base_ok  (o_base_ok),
    .o_index_ok (o_index_ok),
    .o_scale    (o_scale),
    .o_disp_sz  (o_disp_sz),
    .o_rip_rel  (o_rip_rel),
    .o_need_sib (o_need_sib)
);

// File: tb/test_addr_form_dec.sv
// Sweeps every modrm byte in every width and every scaled-index byte in the
// wide widths, comparing against an arithmetic model of the requirements.
module test_addr_form_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] i_modrm = '0;
    logic [7:0] i_sib = '0;
    logic       i_rex_b = 1'b0;
    logic       i_rex_x = 1'b0;
    logic       i_rex_r = 1'b0;
    logic [1:0] i_amode = '0;
    logic       o_is_reg;
    logic [3:0] o_reg_fld;
    logic [3:0] o_base;
    logic       o_base_ok;
    logic [3:0] o_index;
    logic       o_index_ok;
    logic [3:0] o_scale;
    logic [1:0] o_disp_sz;
    logic       o_rip_rel;
    logic       o_need_sib;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    addr_form_dec i_addr_form_dec (
        .clk(clk), .rst_n(rst_n), .i_modrm(i_modrm), .i_sib(i_sib),
        .i_rex_b(i_rex_b), .i_rex_x(i_rex_x), .i_rex_r(i_rex_r), .i_amode(i_amode),
        .o_is_reg(o_is_reg), .o_reg_fld(o_reg_fld), .o_base(o_base), .o_base_ok(o_base_ok),
        .o_index(o_index), .o_index_ok(o_index_ok), .o_scale(o_scale),
        .o_disp_sz(o_disp_sz), .o_rip_rel(o_rip_rel), .o_need_sib(o_need_sib)
    );

    function automatic logic [18:0] actual_word();
        return {o_is_reg, o_base, o_base_ok, o_index, o_index_ok, o_scale, o_disp_sz, o_rip_rel, o_need_sib};
    endfunction

    // Arithmetic model: {is_reg, base, base_ok, index, index_ok, scale, disp, rip, sib}
    function automatic logic [18:0] model(input logic [1:0] am, input logic [7:0] m,
                                          input logic [7:0] s, input logic rb, input logic rx);
        logic w16, w64, b, x, isr, bok, iok, rip, sb;
        logic [1:0] md, dsp;
        logic [2:0] rm;
        logic [3:0] bse, ix, sc;
        w16 = (am == 2'd0); w64 = (am == 2'd2);
        b = rb & w64; x = rx & w64;
        md = m[7:6]; rm = m[2:0];
        isr = 0; bok = 0; iok = 0; rip = 0; sb = 0; dsp = 0; bse = 0; ix = 0; sc = 0;
        if (md == 2'd3) begin
            isr = 1; bse = {b, rm};
        end else if (w16) begin
            bok = 1;
            if (rm[2]) bse = (rm[1:0] == 0) ? 4'd6 : (rm[1:0] == 1) ? 4'd7 : (rm[1:0] == 2) ? 4'd5 : 4'd3;
            else bse = rm[1] ? 4'd5 : 4'd3;
            iok = !rm[2];
            ix = iok ? (rm[0] ? 4'd7 : 4'd6) : 4'd0;
            sc = iok ? 4'd1 : 4'd0;
            dsp = md;
            if (md == 0 && rm == 6) begin bok = 0; bse = 0; dsp = 2; end
        end else begin
            dsp = (md == 1) ? 2'd1 : (md == 2) ? 2'd3 : 2'd0;
            if (rm == 4) begin
                sb = 1; bok = 1; bse = {b, s[2:0]};
                ix = {x, s[5:3]}; iok = (ix != 4);
                sc = iok ? (4'd1 << s[7:6]) : 4'd0;
                if (!iok) ix = 0;
                if (s[2:0] == 5 && md == 0) begin bok = 0; bse = 0; dsp = 3; end
            end else if (rm == 5 && md == 0) begin
                dsp = 3; rip = w64;
            end else begin
                bok = 1; bse = {b, rm};
            end
        end
        return {isr, bse, bok, ix, iok, sc, dsp, rip, sb};
    endfunction

    function automatic string tag_of(input logic [1:0] am, input logic [7:0] m,
                                     input logic [7:0] s, input logic rb, input logic rx, input logic rr);
        if (am != 2'd2 && (rb | rx | rr || am == 2'd3)) return "R10";
        if (m[7:6] == 2'd3) return "R2";
        if (am == 2'd0) return (m[2:0] == 3'd4) ? "R11" : "R8";
        if (m[2:0] == 3'd4) begin
            if (s[2:0] == 3'd5 && m[7:6] == 2'd0) return "R7";
            if ({rx & (am == 2'd2), s[5:3]} == 4'd4 || s[7:6] != 2'd0) return "R6";
            return "R5";
        end
        if (m[2:0] == 3'd5 && m[7:6] == 2'd0) return "R4";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Apply one vector, then check outputs one clock later.
    task automatic run_vec(input logic [1:0] am, input logic [7:0] m, input logic [7:0] s,
                           input logic rb, input logic rx, input logic rr);
        @(negedge clk);
        i_amode = am; i_modrm = m; i_sib = s; i_rex_b = rb; i_rex_x = rx; i_rex_r = rr;
        @(negedge clk);
        check(tag_of(am, m, s, rb, rx, rr), actual_word(), model(am, m, s, rb, rx));
        check("R9", {15'd0, o_reg_fld}, {15'd0, rr & (am == 2'd2), m[5:3]});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset forces zero outputs despite active inputs
        i_amode = 2'd2; i_modrm = 8'h04; i_sib = 8'hFF; i_rex_b = 1; i_rex_x = 1; i_rex_r = 1;
        repeat (3) @(negedge clk);
        check("R1", actual_word(), 19'd0);
        check("R1", {15'd0, o_reg_fld}, 19'd0);
        rst_n = 1'b1;
        // R1: latency, first result appears after one edge
        @(negedge clk);
        check("R1", actual_word(), model(2'd2, 8'h04, 8'hFF, 1, 1));

        // Sweep: every width, every modrm byte, every extension combination
        for (int am = 0; am < 4; am++)
            for (int m = 0; m < 256; m++)
                for (int r = 0; r < 8; r++)
                    run_vec(am[1:0], m[7:0], m[7:0] ^ 8'h5A, r[0], r[1], r[2]);

        // Sweep: every scaled-index byte in the wide widths (R5, R6, R7)
        for (int am = 1; am < 3; am++)
            for (int md = 0; md < 3; md++)
                for (int s = 0; s < 256; s++)
                    for (int r = 0; r < 4; r++)
                        run_vec(am[1:0], {md[1:0], s[2:0], 3'd4}, s[7:0], r[0], r[1], 1'b0);

        // R1: reset mid-run clears the outputs again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", actual_word(), 19'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule